// File: doc/BRIEF.md
# Toggle-Loop Enable Crosser

This block carries single-cycle enable events, along with a data word for each, from a source clock domain into an unrelated destination clock domain. It uses a closed handshake loop built from two toggle registers. The source register flips to the opposite of the last value the destination reported back. The destination register follows the source register through a synchronizer. Every flip the destination sees becomes exactly one destination-cycle enable, and that enable loads the word that the source side is holding.

Because the source register loads the inverse of the fed-back value, the loop limits its own rate. The source cannot launch a new event until the destination has taken the previous one and that acknowledge has come back through a source-side synchronizer.

The source side is a valid/ready stream. A word is accepted on an active source edge when `src_valid` and `src_ready` are both high. `src_ready` stays low while a transfer is in flight. A request made while `src_ready` is low is not queued. It is dropped and flagged.

The destination side has no back-pressure. `dst_valid` is a one-cycle qualifier and must be consumed when it appears.

A clock-forwarding variant launches a transfer on every armed source edge whatever `src_valid` is. This reproduces the source edge stream as destination enables, at the throttled rate. A second parameter moves every source-side register to the falling edge of `src_clk`, so the block can sit on an interface that launches on that edge.

Top module: `tl_enable_crosser`

## Requirements
- R1: `src_ready` is high exactly when the loop is armed, meaning no transfer is in flight. A transfer is accepted on an active source edge where `src_ready` is high and `src_valid` is high, and `src_ready` is low on the next source cycle.
- R2: The word on `src_data` is registered at acceptance. That held word stays unchanged until the next acceptance.
- R3: Each accepted transfer produces exactly one `dst_valid` pulse, one destination cycle long. The number of pulses equals the number of accepted transfers.
- R4: `dst_data` changes only in the cycle where `dst_valid` is high. At that point it carries the accepted word, and words arrive in acceptance order.
- R5: A `src_valid` that is high on an active source edge while `src_ready` is low is dropped. No destination pulse is produced for it, and `src_overrun` is high for the following source cycle.
- R6: After both resets, `src_ready` is 1, and `dst_valid`, `dst_data` and `src_overrun` are 0. No enable appears until a transfer is accepted.
- R7: With `FWD_CLOCK`=1, `src_valid` is ignored and every armed active source edge launches a transfer, so enables keep flowing with `src_valid` held at 0.
- R8: With `SRC_NEGEDGE`=1, all source-side registers act on the falling edge of `src_clk`. Delivery still meets R3.
- R9: Delivery under R3 and R4 holds when the destination clock is either slower or faster than the source clock, with unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock |
| src_rst_n | input | 1 | Source asynchronous reset, active low |
| src_valid | input | 1 | Source request or enable |
| src_ready | output | 1 | Loop armed; request is accepted this edge |
| src_data | input | DATA_W | Word that goes with the request |
| src_overrun | output | 1 | One-cycle flag for a dropped request |
| dst_clk | input | 1 | Destination clock |
| dst_rst_n | input | 1 | Destination asynchronous reset, active low |
| dst_valid | output | 1 | One-cycle destination enable |
| dst_data | output | DATA_W | Captured word, valid with `dst_valid` |

## Verification
The bench runs a destination clock slower than the source, then switches it to a faster one. In both settings it checks that every accepted word comes out once and in order.

It fires a request immediately after an acceptance. A design that queued or forwarded that request would deliver an extra or reordered word, and a design that missed it would leave `src_overrun` low.

A second instance runs in forwarding mode on the falling edge with `src_valid` tied low. A design that still gated on `src_valid` would produce no enables, and one that broke the loop would let the count of accepts drift from the count of pulses by more than the one transfer in flight.

// File: rtl/tl_cdc_pkg.sv
package tl_cdc_pkg;
  localparam int unsigned MIN_SYNC = 2;

  function automatic int unsigned sync_depth(input int unsigned req);
    return (req < MIN_SYNC) ? MIN_SYNC : req;
  endfunction
endpackage

// File: rtl/tl_sync_chain.sv
module tl_sync_chain #(
  parameter int unsigned STAGES   = 2,
  parameter bit          NEG_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  if (NEG_EDGE) begin : g_fall
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
    end
  end else begin : g_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tl_src_side.sv
module tl_src_side #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          FWD_CLOCK   = 1'b0,
  parameter bit          SRC_NEGEDGE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_data,
  input  logic              ack_loop,
  output logic              ready,
  output logic              overrun,
  output logic              tgl,
  output logic [DATA_W-1:0] hold
);
  logic              fb;
  logic              tgl_q, ovr_q;
  logic [DATA_W-1:0] hold_q;
  logic              armed, fire, drop;
  logic              tgl_d, ovr_d;
  logic [DATA_W-1:0] hold_d;

  // acknowledge from the destination, brought into this domain
  tl_sync_chain #(.STAGES(SYNC_STAGES), .NEG_EDGE(SRC_NEGEDGE)) u_fb (
    .clk(clk), .rst_n(rst_n), .d(ack_loop), .q(fb)
  );

  always_comb begin
    armed  = (tgl_q == fb);
    fire   = armed & (FWD_CLOCK ? 1'b1 : req_valid);
    drop   = FWD_CLOCK ? 1'b0 : (req_valid & ~armed);
    tgl_d  = fire ? ~fb : tgl_q;
    hold_d = fire ? req_data : hold_q;
    ovr_d  = drop;
  end

  if (SRC_NEGEDGE) begin : g_fall
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgl_q  <= 1'b0;
        ovr_q  <= 1'b0;
        hold_q <= '0;
      end else begin
        tgl_q  <= tgl_d;
        ovr_q  <= ovr_d;
        hold_q <= hold_d;
      end
    end
  end else begin : g_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgl_q  <= 1'b0;
        ovr_q  <= 1'b0;
        hold_q <= '0;
      end else begin
        tgl_q  <= tgl_d;
        ovr_q  <= ovr_d;
        hold_q <= hold_d;
      end
    end
  end

  assign ready   = armed;
  assign overrun = ovr_q;
  assign tgl     = tgl_q;
  assign hold    = hold_q;
endmodule

// File: rtl/tl_dst_side.sv
module tl_dst_side #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgl,
  input  logic [DATA_W-1:0] word,
  output logic              ack,
  output logic              en,
  output logic [DATA_W-1:0] data
);
  logic              seen, prev, pulse;
  logic              en_q;
  logic [DATA_W-1:0] data_q;

  // first stage of this chain may go metastable; edge detect uses the last
  tl_sync_chain #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_fwd (
    .clk(clk), .rst_n(rst_n), .d(tgl), .q(seen)
  );

  assign pulse = seen ^ prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      prev <= seen;
      en_q <= pulse;
      if (pulse) data_q <= word;
    end
  end

  // acknowledge taken after the capture edge so the word is already stored
  assign ack  = prev;
  assign en   = en_q;
  assign data = data_q;
endmodule

// File: rtl/tl_enable_crosser.sv
module tl_enable_crosser #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          FWD_CLOCK   = 1'b0,
  parameter bit          SRC_NEGEDGE = 1'b0
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_overrun,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  import tl_cdc_pkg::*;
  localparam int unsigned DEPTH = sync_depth(SYNC_STAGES);

  logic              loop_tgl, loop_ack;
  logic [DATA_W-1:0] xfer_word;

  tl_src_side #(
    .DATA_W(DATA_W), .SYNC_STAGES(DEPTH),
    .FWD_CLOCK(FWD_CLOCK), .SRC_NEGEDGE(SRC_NEGEDGE)
  ) u_src (
    .clk(src_clk), .rst_n(src_rst_n), .req_valid(src_valid),
    .req_data(src_data), .ack_loop(loop_ack), .ready(src_ready),
    .overrun(src_overrun), .tgl(loop_tgl), .hold(xfer_word)
  );

  tl_dst_side #(.DATA_W(DATA_W), .SYNC_STAGES(DEPTH)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_n), .tgl(loop_tgl), .word(xfer_word),
    .ack(loop_ack), .en(dst_valid), .data(dst_data)
  );
endmodule

// File: rtl/tl_enable_crosser_chk.sv
module tl_enable_crosser_chk #(
  parameter int unsigned DATA_W      = 8,
  parameter bit          FWD_CLOCK   = 1'b0,
  parameter bit          SRC_NEGEDGE = 1'b0
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              src_valid,
  input logic              src_ready,
  input logic              src_overrun,
  input logic [DATA_W-1:0] xfer_word,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              dst_valid,
  input logic [DATA_W-1:0] dst_data
);
  logic sclk;
  assign sclk = SRC_NEGEDGE ? ~src_clk : src_clk;

  assert_ready_drops_R1: assert property (@(posedge sclk) disable iff (!src_rst_n)
    (src_ready && (FWD_CLOCK || src_valid)) |=> !src_ready);

  assert_word_held_R2: assert property (@(posedge sclk) disable iff (!src_rst_n)
    !src_ready |=> $stable(xfer_word));

  assert_single_pulse_R3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> !dst_valid);

  assert_data_quiet_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !dst_valid |-> $stable(dst_data));

  assert_overrun_cause_R5: assert property (@(posedge sclk) disable iff (!src_rst_n)
    src_overrun |-> $past(src_valid && !src_ready && !FWD_CLOCK));
endmodule

bind tl_enable_crosser tl_enable_crosser_chk #(
  .DATA_W(DATA_W), .FWD_CLOCK(FWD_CLOCK), .SRC_NEGEDGE(SRC_NEGEDGE)
) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
  .src_ready(src_ready), .src_overrun(src_overrun), .xfer_word(xfer_word),
  .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_valid(dst_valid),
  .dst_data(dst_data)
);

// File: tb/sim_tl_enable_crosser.sv
`timescale 1ns/1ps
module sim_tl_enable_crosser;
  localparam int W = 8;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  real  dst_half = 3.5;
  always #2 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  logic         src_valid = 1'b0;
  logic [W-1:0] src_data  = '0;
  logic         src_ready, src_overrun, dst_valid;
  logic [W-1:0] dst_data;

  tl_enable_crosser #(.DATA_W(W)) u0 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .src_overrun(src_overrun),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_valid(dst_valid),
    .dst_data(dst_data)
  );

  // forwarding mode on the falling edge, request held low
  logic         f_ready, f_overrun, f_valid;
  logic [W-1:0] f_data, f_cnt = '0;
  tl_enable_crosser #(.DATA_W(W), .FWD_CLOCK(1'b1), .SRC_NEGEDGE(1'b1)) u1 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(1'b0),
    .src_ready(f_ready), .src_data(f_cnt), .src_overrun(f_overrun),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_valid(f_valid),
    .dst_data(f_data)
  );

  int checks = 0, fails = 0;
  int n_acc = 0, n_pulse = 0, f_acc = 0, f_pulse = 0;
  bit counting = 1'b0, done = 1'b0;
  logic [W-1:0] expq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: pushes expected word at the moment acceptance is certain
  task automatic send(input logic [W-1:0] w);
    @(negedge src_clk);
    while (!src_ready) @(negedge src_clk);
    src_valid = 1'b1; src_data = w;
    expq.push_back(w); n_acc++;
    @(negedge src_clk);
    src_valid = 1'b0;
    check(src_ready == 1'b0, "R1 ready low after accept", int'(src_ready), 0);
  endtask

  // monitor: one pulse per transfer, words in order
  logic last_v = 1'b0;
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_valid) begin
        n_pulse++;
        check(!last_v, "R3 single-cycle pulse", int'(last_v), 0);
        if (expq.size() == 0) check(1'b0, "R4 unexpected word", int'(dst_data), -1);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(dst_data == e, "R4 R9 word order", int'(dst_data), int'(e));
        end
      end
      last_v = dst_valid;
    end
  end

  always @(posedge src_clk) if (counting && f_ready) f_acc++;
  always @(posedge src_clk) f_cnt <= f_cnt + 1'b1;
  always @(negedge dst_clk) if (counting && f_valid) f_pulse++;

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #30;
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    #1;
    check(src_ready == 1'b1, "R6 ready after reset", int'(src_ready), 1);
    check(dst_valid == 1'b0, "R6 no enable after reset", int'(dst_valid), 0);
    check(dst_data == '0, "R6 data after reset", int'(dst_data), 0);
    check(src_overrun == 1'b0, "R6 overrun after reset", int'(src_overrun), 0);
    counting = 1'b1;

    // destination slower than source
    for (int i = 0; i < 6; i++) send(W'(8'h10 + i));

    // request while in flight: dropped and flagged
    send(8'hA5);
    src_valid = 1'b1; src_data = 8'hEE;
    @(negedge src_clk);
    src_valid = 1'b0;
    check(src_overrun == 1'b1, "R5 overrun flagged", int'(src_overrun), 1);
    @(negedge src_clk);
    check(src_overrun == 1'b0, "R5 overrun one cycle", int'(src_overrun), 0);
    send(8'h5A);

    // destination faster than source
    dst_half = 1.3;
    for (int i = 0; i < 6; i++) send(W'(8'hC0 + 3 * i));

    repeat (60) @(negedge src_clk);
    counting = 1'b0;
    repeat (4) @(negedge src_clk);
    check(expq.size() == 0, "R3 all words delivered", expq.size(), 0);
    check(n_pulse == n_acc, "R3 pulse count", n_pulse, n_acc);
    check(f_pulse > 10, "R7 forwarding ignores valid", f_pulse, 11);
    check((f_acc - f_pulse) >= 0 && (f_acc - f_pulse) <= 1,
          "R8 falling-edge loop balance", f_acc - f_pulse, 0);
    check(f_overrun == 1'b0, "R7 no overrun in forwarding", int'(f_overrun), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule